// File: doc/BRIEF.md
# Store Queue with Read-Miss Bypass

This block is a small posted-write queue placed between a write-through cache and the next memory level. The cache hands it stores as block-aligned entries. Each entry carries a block address, a per-word byte-lane-free word mask and the word data. A store is complete from the processor's point of view as soon as the queue accepts it. The queue then empties itself to memory, oldest entry first, whenever the shared memory port has nothing more urgent to do.

A read miss may overtake every queued write, but only after its block address has been compared against all occupied entries. When no entry holds the same block, the read takes the memory port at once. When an entry does hold that block, the read is held, and the queue keeps draining until no matching entry is left. Only then is the read sent. A dirty block evicted on a read miss is written into the queue as a full-mask store. The miss read therefore reaches memory before that victim write.

A store to a block that is already queued is folded into the youngest entry for that block. That entry's mask and words are updated, and no new slot is used. There are two exceptions. Stores to the I/O region, which starts at the parameter `IO_BASE`, never fold. A store also does not fold into the head entry in the cycle that the head's write is being accepted by memory.

Top module: `wbuf_rdprio`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, the queue is empty: `mem_req` is low when `rd_valid` is low, and `st_ready` is high.
- R2: Queued entries are written to memory in acceptance order. A write presents `mem_we`=1, `mem_addr` = block address followed by two zero word-offset bits, `mem_wmask` = the entry's accumulated mask (bit w = word w, at data bits 32w+31..32w), and the latest data for each masked word. An entry leaves the queue in the cycle where `mem_gnt` is high.
- R3: With four entries occupied and no fold possible, `st_ready` is low and the store is not taken.
- R4: A store outside the I/O region, whose block matches the youngest entry holding that block, ORs its mask into that entry and overwrites those words without using a slot. This works even when the queue is full.
- R5: Stores to blocks at or above `IO_BASE` (word address) never fold; each one is written to memory as its own entry.
- R6: A read whose block matches no entry drives `mem_req`=1, `mem_we`=0 and `mem_addr`=`rd_addr` in the same cycle, ahead of any queued write. `rd_ready` equals `mem_gnt` in that cycle.
- R7: A read whose block matches an entry is not sent. The port drains the queue instead, and the read goes out in the first cycle after no matching entry remains.
- R8: The port drains the head entry whenever no read can be sent. With the queue empty and no read, `mem_req` is low.
- R9: A store to the head entry's block, in the cycle that the head's write is accepted, takes a new slot rather than folding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_blk | input | 14 | Store block address (word address without the two offset bits) |
| st_mask | input | 4 | Words of the block written by the store (must be nonzero) |
| st_data | input | 128 | Store words, word w at bits 32w+31..32w |
| st_ready | output | 1 | Store accepted this cycle when high with `st_valid` |
| rd_valid | input | 1 | Read miss waiting for memory |
| rd_addr | input | 16 | Read word address |
| rd_ready | output | 1 | Read taken by memory this cycle |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | 1 = queued write, 0 = read miss |
| mem_addr | output | 16 | Word address of the request |
| mem_wdata | output | 128 | Write words |
| mem_wmask | output | 4 | Words to write |
| mem_gnt | input | 1 | Memory accepts the current request this cycle |

## Verification
All of the block's outputs are combinational functions of the queue state and the current inputs. Port choice, `rd_ready`, `st_ready` and the write payload are therefore due in the same cycle as the stimulus. A fold, a new slot or a pop shows up one clock edge later, in the outputs of the next cycle. The bench drives inputs on the falling edge and compares every output one nanosecond later, against a queue model that was updated at the preceding rising edge. Each comparison therefore sees exactly one edge's worth of state change.

// File: rtl/wbuf_pkg.sv
// Shared types for the store queue with read bypass.
// Assumes nothing beyond SystemVerilog enum support.
package wbuf_pkg;
    // Which requester owns the memory port in the current cycle.
    typedef enum logic [1:0] {
        SEL_IDLE  = 2'd0,
        SEL_READ  = 2'd1,
        SEL_DRAIN = 2'd2
    } port_sel_e;
endpackage

// File: rtl/wbuf_cam.sv
// Associative block-address compare: flags every occupied entry whose
// block address equals the key. Purely combinational.
module wbuf_cam #(
    parameter int DEPTH = 4,
    parameter int BW    = 14
) (
    input  logic [BW-1:0]    key,
    input  logic [DEPTH-1:0] vld,
    input  logic [BW-1:0]    blk [DEPTH],
    output logic [DEPTH-1:0] hit
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        // One comparator per entry.
        assign hit[i] = vld[i] && (blk[i] == key);
    end
endmodule

// File: rtl/wbuf_youngest.sv
// Picks the youngest flagged entry of a circular queue, walking from the
// head (oldest) forward. Assumes DEPTH is a power of two and at least 2.
module wbuf_youngest #(
    parameter int DEPTH = 4,
    parameter int PW    = 2
) (
    input  logic [DEPTH-1:0] hit,
    input  logic [PW-1:0]    head,
    output logic             found,
    output logic [PW-1:0]    idx
);
    // Later (younger) matches overwrite earlier ones.
    always_comb begin
        found = 1'b0;
        idx   = head;
        for (int k = 0; k < DEPTH; k++) begin
            if (hit[head + PW'(k)]) begin
                found = 1'b1;
                idx   = head + PW'(k);
            end
        end
    end
endmodule

// File: rtl/wbuf_arb.sv
// Memory-port arbiter: an unconflicted read wins, otherwise the head
// entry drains. Assumes the memory accepts in any cycle with gnt high.
module wbuf_arb
    import wbuf_pkg::*;
(
    input  logic      rd_valid,
    input  logic      rd_conflict,
    input  logic      nonempty,
    input  logic      mem_gnt,
    output port_sel_e sel,
    output logic      rd_ready,
    output logic      drain_fire
);
    // Priority choice for this cycle.
    always_comb begin
        if (rd_valid && !rd_conflict) sel = SEL_READ;
        else if (nonempty)            sel = SEL_DRAIN;
        else                          sel = SEL_IDLE;
    end

    assign rd_ready   = (sel == SEL_READ)  && mem_gnt;
    assign drain_fire = (sel == SEL_DRAIN) && mem_gnt;
endmodule

// File: rtl/wbuf_rdprio.sv
// Posted-write queue between a write-through cache and memory.
// Holds DEPTH block entries (mask + words), folds stores to a queued
// block, lets read misses bypass unless their block is queued, and drains
// oldest first. Assumes st_mask is nonzero and DEPTH is a power of two.
module wbuf_rdprio
    import wbuf_pkg::*;
#(
    parameter int             AW      = 16,
    parameter int             DW      = 32,
    parameter int             WORDS   = 4,
    parameter int             DEPTH   = 4,
    parameter logic [AW-1:0]  IO_BASE = 16'hF000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             st_valid,
    input  logic [AW-$clog2(WORDS)-1:0]      st_blk,
    input  logic [WORDS-1:0]                 st_mask,
    input  logic [WORDS*DW-1:0]              st_data,
    output logic                             st_ready,
    input  logic                             rd_valid,
    input  logic [AW-1:0]                    rd_addr,
    output logic                             rd_ready,
    output logic                             mem_req,
    output logic                             mem_we,
    output logic [AW-1:0]                    mem_addr,
    output logic [WORDS*DW-1:0]              mem_wdata,
    output logic [WORDS-1:0]                 mem_wmask,
    input  logic                             mem_gnt
);
    localparam int            OFF_W  = $clog2(WORDS);
    localparam int            BW     = AW - OFF_W;
    localparam int            PW     = $clog2(DEPTH);
    localparam logic [PW:0]   FULL   = (PW+1)'(DEPTH);
    localparam logic [BW-1:0] IO_BLK = IO_BASE[AW-1:OFF_W];

    logic [DEPTH-1:0]    e_vld;
    logic [DEPTH-1:0]    e_io;
    logic [BW-1:0]       e_blk  [DEPTH];
    logic [WORDS-1:0]    e_mask [DEPTH];
    logic [WORDS*DW-1:0] e_data [DEPTH];
    logic [PW-1:0]       head, tail;
    logic [PW:0]         count;

    logic [DEPTH-1:0] hit_st, hit_rd;
    logic             st_found, merge_en, st_io, st_fire, alloc;
    logic [PW-1:0]    st_idx;
    logic             rd_conflict, drain_fire;
    port_sel_e        sel;

    // Store-side compare and youngest-match selection.
    wbuf_cam #(.DEPTH(DEPTH), .BW(BW)) u_cam_st (
        .key(st_blk), .vld(e_vld), .blk(e_blk), .hit(hit_st)
    );
    wbuf_youngest #(.DEPTH(DEPTH), .PW(PW)) u_young (
        .hit(hit_st), .head(head), .found(st_found), .idx(st_idx)
    );

    // Read-side compare against every queued block.
    wbuf_cam #(.DEPTH(DEPTH), .BW(BW)) u_cam_rd (
        .key(rd_addr[AW-1:OFF_W]), .vld(e_vld), .blk(e_blk), .hit(hit_rd)
    );
    assign rd_conflict = rd_valid && (|hit_rd);

    wbuf_arb u_arb (
        .rd_valid(rd_valid), .rd_conflict(rd_conflict), .nonempty(count != '0),
        .mem_gnt(mem_gnt), .sel(sel), .rd_ready(rd_ready), .drain_fire(drain_fire)
    );

    // Fold decision and store acceptance.
    assign st_io    = (st_blk >= IO_BLK);
    assign merge_en = st_found && !e_io[st_idx] && !(drain_fire && (st_idx == head));
    assign st_ready = merge_en || (count != FULL);
    assign st_fire  = st_valid && st_ready;
    assign alloc    = st_fire && !merge_en;

    // Memory port payload.
    assign mem_req   = (sel != SEL_IDLE);
    assign mem_we    = (sel == SEL_DRAIN);
    assign mem_addr  = (sel == SEL_READ) ? rd_addr : {e_blk[head], {OFF_W{1'b0}}};
    assign mem_wdata = e_data[head];
    assign mem_wmask = e_mask[head];

    // Occupancy, pointers and entry control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_vld <= '0;
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (drain_fire) begin
                e_vld[head] <= 1'b0;
                head        <= head + PW'(1);
            end
            if (alloc) begin
                e_vld[tail] <= 1'b1;
                tail        <= tail + PW'(1);
            end
            count <= count + {{PW{1'b0}}, alloc} - {{PW{1'b0}}, drain_fire};
        end
    end

    // Entry payload: fill on a new slot, fold masked words on a merge.
    always_ff @(posedge clk) begin
        if (alloc) begin
            e_blk[tail]  <= st_blk;
            e_io[tail]   <= st_io;
            e_mask[tail] <= st_mask;
            e_data[tail] <= st_data;
        end else if (st_fire) begin
            e_mask[st_idx] <= e_mask[st_idx] | st_mask;
            for (int w = 0; w < WORDS; w++) begin
                if (st_mask[w]) e_data[st_idx][w*DW +: DW] <= st_data[w*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/wbuf_rdprio_chk.sv
// Property checker for the store queue, attached by bind below.
// Observes ports and the signals passed between the queue's sub-blocks.
module wbuf_rdprio_chk #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int PW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_ready,
    input logic          st_io,
    input logic          merge_en,
    input logic          alloc,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic          rd_conflict,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_gnt,
    input logic          drain_fire,
    input logic [AW-1:0] rd_addr,
    input logic [AW-1:0] mem_addr,
    input logic [PW-1:0] head,
    input logic [PW-1:0] merge_idx,
    input logic [PW:0]   count
);
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> int'(count) == int'($past(count)) + int'($past(alloc)) - int'($past(drain_fire)));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);
    p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) == DEPTH && !merge_en) |-> !st_ready);
    p_io_nomerge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        merge_en |-> !st_io);
    p_read_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_conflict) |-> (mem_req && !mem_we && mem_addr == rd_addr));
    p_rd_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (mem_gnt && mem_req && !mem_we));
    p_read_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_conflict |-> (!rd_ready && mem_we));
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !rd_valid) |-> !mem_req);
    p_head_fold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_fire && merge_en) |-> (merge_idx != head));
endmodule

bind wbuf_rdprio wbuf_rdprio_chk #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .st_io(st_io),
    .merge_en(merge_en), .alloc(alloc), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_conflict(rd_conflict), .mem_req(mem_req), .mem_we(mem_we),
    .mem_gnt(mem_gnt), .drain_fire(drain_fire), .rd_addr(rd_addr),
    .mem_addr(mem_addr), .head(head), .merge_idx(st_idx), .count(count)
);

// File: tb/tb_wbuf_rdprio.sv
`timescale 1ns/1ps
module tb_wbuf_rdprio;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic [13:0]  st_blk = '0;
    logic [3:0]   st_mask = '0;
    logic [127:0] st_data = '0;
    logic         st_ready;
    logic         rd_valid = 1'b0;
    logic [15:0]  rd_addr = '0;
    logic         rd_ready;
    logic         mem_req, mem_we;
    logic [15:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [3:0]   mem_wmask;
    logic         mem_gnt = 1'b0;

    int errs = 0;
    int checks = 0;

    typedef struct {
        int           blk;
        bit           io;
        bit [3:0]     mask;
        logic [127:0] data;
    } ent_t;
    ent_t q[$];

    always #2.5 clk = ~clk;

    wbuf_rdprio dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_blk(st_blk),
        .st_mask(st_mask), .st_data(st_data), .st_ready(st_ready),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_gnt(mem_gnt)
    );

    function automatic logic [127:0] wexp(bit [3:0] m);
        logic [127:0] r;
        for (int w = 0; w < 4; w++) r[w*32 +: 32] = {32{m[w]}};
        return r;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, compare 1 ns later, advance the model.
    task automatic step(bit sv, int blk, bit [3:0] m, logic [127:0] d, bit rv, int ra, bit g);
        int rb, mi;
        bit conf, e_rd, e_dr, e_rdy, drain, merge, e_st;
        string tm, ts;
        logic [15:0] e_addr;
        @(negedge clk);
        st_valid = sv; st_blk = 14'(blk); st_mask = m; st_data = d;
        rd_valid = rv; rd_addr = 16'(ra); mem_gnt = g;
        #1;
        rb = ra >> 2;
        conf = 1'b0;
        foreach (q[i]) if (q[i].blk == rb) conf = 1'b1;
        conf = conf && rv;
        e_rd  = rv && !conf;
        e_dr  = !e_rd && (q.size() > 0);
        e_rdy = e_rd && g;
        drain = e_dr && g;
        e_addr = e_rd ? 16'(ra) : (e_dr ? 16'(q[0].blk << 2) : 16'h0);
        mi = -1;
        foreach (q[i]) if (q[i].blk == blk) mi = i;
        merge = (mi >= 0) && !q[mi].io && !(mi == 0 && drain);
        e_st  = merge || (q.size() < 4);
        tm = e_rd ? "R6" : (conf ? "R7" : (e_dr ? (q[0].io ? "R5" : "R2") : "R8"));
        ts = merge ? "R4" : ((mi == 0 && drain) ? "R9" : ((q.size() == 4) ? "R3" : "R2"));
        chk(st_ready == e_st, ts, "st_ready", 128'(st_ready), 128'(e_st));
        chk(rd_ready == e_rdy, tm, "rd_ready", 128'(rd_ready), 128'(e_rdy));
        chk(mem_req == (e_rd || e_dr), tm, "mem_req", 128'(mem_req), 128'(e_rd || e_dr));
        if (e_rd || e_dr) begin
            chk(mem_we == e_dr, tm, "mem_we", 128'(mem_we), 128'(e_dr));
            chk(mem_addr == e_addr, tm, "mem_addr", 128'(mem_addr), 128'(e_addr));
        end
        if (e_dr) begin
            chk(mem_wmask == q[0].mask, tm, "mem_wmask", 128'(mem_wmask), 128'(q[0].mask));
            chk((mem_wdata & wexp(q[0].mask)) == (q[0].data & wexp(q[0].mask)), tm,
                "mem_wdata", mem_wdata & wexp(q[0].mask), q[0].data & wexp(q[0].mask));
        end
        if (sv && merge) begin
            q[mi].mask |= m;
            for (int w = 0; w < 4; w++) if (m[w]) q[mi].data[w*32 +: 32] = d[w*32 +: 32];
        end
        if (drain) void'(q.pop_front());
        if (sv && e_st && !merge) begin
            ent_t e;
            e.blk = blk; e.io = (blk >= ('hF000 >> 2)); e.mask = m; e.data = d;
            q.push_back(e);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: empty after reset
        chk(mem_req == 1'b0, "R1", "mem_req after reset", 128'(mem_req), 128'(0));
        chk(st_ready == 1'b1, "R1", "st_ready after reset", 128'(st_ready), 128'(1));

        // R4: four single-word stores to one block fold into one entry
        for (int w = 0; w < 4; w++) step(1, 1, 4'(1 << w), rnd128(), 0, 0, 0);
        // Fill remaining slots, then R3 stall, then R4 fold while full
        step(1, 2, 4'b0001, rnd128(), 0, 0, 0);
        step(1, 3, 4'b0100, rnd128(), 0, 0, 0);
        step(1, 4, 4'b1000, rnd128(), 0, 0, 0);
        step(1, 5, 4'b0001, rnd128(), 0, 0, 0);
        step(1, 3, 4'b0010, rnd128(), 0, 0, 0);
        // R6: unconflicted read bypasses the full queue
        step(0, 0, 0, 0, 1, 9*4 + 1, 1);
        // R7: conflicting read held while blocks 1 and 2 drain
        repeat (4) step(0, 0, 0, 0, 1, 2*4 + 2, 1);
        // R2/R8: drain the rest with a stalling grant, then idle
        repeat (4) step(0, 0, 0, 0, 0, 0, 0);
        repeat (6) step(0, 0, 0, 0, 0, 0, 1);
        // R5: I/O stores to one block never fold
        step(1, 'h3C00, 4'b0001, rnd128(), 0, 0, 0);
        step(1, 'h3C00, 4'b0010, rnd128(), 0, 0, 0);
        repeat (3) step(0, 0, 0, 0, 0, 0, 1);
        // R9: store to the head block while the head drains takes a new slot
        step(1, 7, 4'b0001, rnd128(), 0, 0, 0);
        step(1, 7, 4'b0010, rnd128(), 0, 0, 1);
        repeat (2) step(0, 0, 0, 0, 0, 0, 1);
        // Victim block queued, miss read to another block goes first (R6)
        step(1, 10, 4'hF, rnd128(), 0, 0, 0);
        step(0, 0, 0, 0, 1, 11*4, 1);
        repeat (2) step(0, 0, 0, 0, 0, 0, 1);

        // Mixed traffic over a few blocks, including the I/O region
        for (int c = 0; c < 3000; c++) begin
            int b;
            bit [3:0] m;
            b = ($urandom % 8 == 0) ? 'h3C00 : int'(1 + $urandom % 4);
            m = 4'($urandom % 15 + 1);
            step(($urandom % 2) == 0, b, m, rnd128(),
                 ($urandom % 3) == 0, int'(($urandom % 5) * 4 + $urandom % 4),
                 ($urandom % 4) != 0);
        end
        repeat (8) step(0, 0, 0, 0, 0, 0, 1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule